// File: doc/BRIEF.md
# Card Bus Clock Generator

This block derives the clock that drives a memory-card bus from the system clock. The system clock is the fastest source available. A small exponent register selects how far it is divided down, in powers of two. Software controls the output with single-cycle strobes: one starts the clock, one asks it to halt, and one clears a sticky flag. The halt flag rises only once the output has actually come to rest.

A halt request never cuts a card-clock period short. The generator finishes the period it is in and parks the output low. It then drops its running status and sets the off flag. A new exponent is accepted only while the output is at rest, so one period is never a mixture of two rates.

The command path asks to launch a command through a strobe, together with an optional initialisation flag. Without the flag, the launch pulse follows at once. With the flag, the block first drives a burst of complete card-clock periods, 80 by default, and then releases the launch pulse. The command and data shift logic that follows the launch is outside this block.

Top module: `cardclk_gen`

## Requirements
- R1: The exponent n selects a card-clock half-period of 2^n system cycles, so one full period is 2^(n+1) cycles. Legal values are 0 to MAX_EXP, which is 6 by default. After reset the exponent is MAX_EXP, and `rate_out` always shows the exponent in force.
- R2: A write whose value is greater than MAX_EXP (7 in the default 3-bit field) is ignored, and the previous exponent is kept.
- R3: An exponent write arriving while the clock runs is ignored.
- R4: A start strobe while the clock is stopped begins output with a full low half-period: `card_clk` stays low for 2^n cycles after the start edge. A start strobe while the clock is running has no effect. When start and stop arrive in the same cycle while the clock is stopped, it stays stopped.
- R5: A stop strobe takes effect only at the falling edge that ends the current period. This includes a stop that arrives in that very cycle. The output is low from that edge on, so no shortened high or low phase ever appears.
- R6: `clk_running` goes to 1 in the cycle after an accepted start. It returns to 0 in the same cycle in which the final falling edge appears.
- R7: `clk_off` is set in the cycle the clock halts and stays set until an `off_clr` strobe. If a halt and a clear arrive in the same cycle, the flag ends up set.
- R8: A `cmd_go` strobe with `cmd_init` low, while no burst is pending, makes `cmd_launch` pulse for one cycle, one cycle later.
- R9: A `cmd_go` strobe with `cmd_init` high raises `init_busy`. `cmd_launch` then pulses exactly once, one cycle after the INIT_CYCLES-th complete card-clock period has ended, and `init_busy` falls in that same cycle. The burst pauses while the clock is stopped.
- R10: A `cmd_go` strobe while `init_busy` is high is ignored.
- R11: After reset, `card_clk`, `clk_running`, `clk_off`, `init_busy` and `cmd_launch` are 0, and `rate_out` is MAX_EXP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the maximum-rate source |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_wr | input | 1 | Strobe: write `rate_in` as the new exponent |
| rate_in | input | RATE_W | Requested division exponent |
| start_stb | input | 1 | Strobe: start the card clock |
| stop_stb | input | 1 | Strobe: request a halt at the end of the period |
| off_clr | input | 1 | Strobe: clear the sticky off flag |
| cmd_go | input | 1 | Strobe: a command is waiting to go |
| cmd_init | input | 1 | Send the initialisation burst before this command |
| card_clk | output | 1 | Card bus clock |
| clk_running | output | 1 | Status: the card clock is running |
| clk_off | output | 1 | Sticky flag: the clock has halted |
| rate_out | output | RATE_W | Exponent in force |
| init_busy | output | 1 | Initialisation burst in progress |
| cmd_launch | output | 1 | One-cycle pulse: the command may be shifted out |

## Verification
The bench builds the block with its defaults: MAX_EXP of 6 and INIT_CYCLES of 80. A 3-bit exponent field therefore also reaches the one illegal code, 7. At exponent 0 the full 80-period burst finishes in about 160 cycles, so it can run end to end. That run also includes a burst paused by a stop and resumed by a start at exponent 1. Exponent 6 stretches a half-period to 64 cycles, which makes halt requests in either phase, start strobes while running and rejected exponent writes easy to place against a cycle-accurate model.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;

    typedef enum logic {
        BURST_IDLE = 1'b0,
        BURST_RUN  = 1'b1
    } burst_state_e;

    function automatic logic exp_is_legal(input int unsigned value, input int unsigned max_exp);
        return value <= max_exp;
    endfunction

endpackage

// File: rtl/cardclk_rate.sv
module cardclk_rate #(
    parameter int MAX_EXP = 6,
    parameter int RATE_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [RATE_W-1:0] val_i,
    input  logic              running_i,
    output logic [RATE_W-1:0] rate_o
);
    typedef struct packed {
        logic [RATE_W-1:0] rate;
    } rate_st_t;

    rate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i && !running_i &&
            cardclk_pkg::exp_is_legal(int'(val_i), MAX_EXP)) begin
            st_d.rate = val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rate <= RATE_W'(MAX_EXP);
        end else begin
            st_q <= st_d;
        end
    end

    assign rate_o = st_q.rate;

    assert_rate_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.rate) <= MAX_EXP);

    assert_rate_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running_i && $past(running_i)) |-> $stable(st_q.rate));

endmodule

// File: rtl/cardclk_div.sv
module cardclk_div #(
    parameter int MAX_EXP = 6,
    parameter int RATE_W  = 3,
    localparam int CNT_W  = (MAX_EXP > 0) ? MAX_EXP : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              clr_i,
    output logic              card_clk_o,
    output logic              running_o,
    output logic              off_o,
    output logic              period_end_o
);
    typedef struct packed {
        logic             run;
        logic             ck;
        logic             pend;
        logic             off;
        logic             fall;
        logic [CNT_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [CNT_W-1:0] half_lim;
    logic             halt;

    always_comb begin
        half_lim = CNT_W'((({(CNT_W+1){1'b0}} | (CNT_W+1)'(1)) << rate_i) - (CNT_W+1)'(1));
    end

    always_comb begin
        st_d      = st_q;
        st_d.fall = 1'b0;
        halt      = 1'b0;
        if (!st_q.run) begin
            if (start_i && !stop_i) begin
                st_d.run = 1'b1;
                st_d.ck  = 1'b0;
                st_d.cnt = '0;
            end
        end else begin
            if (stop_i) begin
                st_d.pend = 1'b1;
            end
            if (st_q.cnt == half_lim) begin
                st_d.cnt = '0;
                st_d.ck  = ~st_q.ck;
                if (st_q.ck) begin
                    st_d.fall = 1'b1;
                    if (st_q.pend || stop_i) begin
                        st_d.run  = 1'b0;
                        st_d.pend = 1'b0;
                        halt      = 1'b1;
                    end
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (halt) begin
            st_d.off = 1'b1;
        end else if (clr_i) begin
            st_d.off = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign card_clk_o   = st_q.ck;
    assign running_o    = st_q.run;
    assign off_o        = st_q.off;
    assign period_end_o = st_q.fall;

    assert_parked_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.run |-> !st_q.ck);

    assert_halt_after_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.run) |-> $past(st_q.ck));

    assert_flag_on_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.run) |-> st_q.off);

    assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.cnt <= half_lim));

endmodule

// File: rtl/cardclk_init.sv
module cardclk_init #(
    parameter int INIT_CYCLES = 80,
    localparam int ICW = $clog2(INIT_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic init_i,
    input  logic period_end_i,
    output logic busy_o,
    output logic launch_o
);
    import cardclk_pkg::*;

    typedef struct packed {
        burst_state_e   state;
        logic [ICW-1:0] cnt;
        logic           launch;
    } init_st_t;

    init_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.launch = 1'b0;
        case (st_q.state)
            BURST_IDLE: begin
                if (go_i) begin
                    if (init_i) begin
                        st_d.state = BURST_RUN;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.launch = 1'b1;
                    end
                end
            end
            BURST_RUN: begin
                if (period_end_i) begin
                    if (st_q.cnt == ICW'(INIT_CYCLES - 1)) begin
                        st_d.state  = BURST_IDLE;
                        st_d.launch = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            default: st_d.state = BURST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state  <= BURST_IDLE;
            st_q.cnt    <= '0;
            st_q.launch <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o   = (st_q.state == BURST_RUN);
    assign launch_o = st_q.launch;

    assert_burst_ends_in_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> st_q.launch);

    assert_burst_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (st_q.cnt <= ICW'(INIT_CYCLES - 1)));

    assert_no_launch_mid_burst_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> !st_q.launch);

endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen #(
    parameter int MAX_EXP     = 6,
    parameter int INIT_CYCLES = 80,
    localparam int RATE_W     = $clog2(MAX_EXP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_wr,
    input  logic [RATE_W-1:0] rate_in,
    input  logic              start_stb,
    input  logic              stop_stb,
    input  logic              off_clr,
    input  logic              cmd_go,
    input  logic              cmd_init,
    output logic              card_clk,
    output logic              clk_running,
    output logic              clk_off,
    output logic [RATE_W-1:0] rate_out,
    output logic              init_busy,
    output logic              cmd_launch
);
    logic [RATE_W-1:0] rate_w;
    logic              running_w;
    logic              period_end_w;

    cardclk_rate #(.MAX_EXP(MAX_EXP), .RATE_W(RATE_W)) u_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (rate_wr),
        .val_i     (rate_in),
        .running_i (running_w),
        .rate_o    (rate_w)
    );

    cardclk_div #(.MAX_EXP(MAX_EXP), .RATE_W(RATE_W)) u_div (
        .clk          (clk),
        .rst_n        (rst_n),
        .rate_i       (rate_w),
        .start_i      (start_stb),
        .stop_i       (stop_stb),
        .clr_i        (off_clr),
        .card_clk_o   (card_clk),
        .running_o    (running_w),
        .off_o        (clk_off),
        .period_end_o (period_end_w)
    );

    cardclk_init #(.INIT_CYCLES(INIT_CYCLES)) u_init (
        .clk          (clk),
        .rst_n        (rst_n),
        .go_i         (cmd_go),
        .init_i       (cmd_init),
        .period_end_i (period_end_w),
        .busy_o       (init_busy),
        .launch_o     (cmd_launch)
    );

    assign clk_running = running_w;
    assign rate_out    = rate_w;

endmodule

// File: tb/tb_cardclk_gen.sv
module tb_cardclk_gen;
    localparam int MAXE  = 6;
    localparam int INITN = 80;
    localparam int RW    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rate_wr = 1'b0, start_stb = 1'b0, stop_stb = 1'b0, off_clr = 1'b0;
    logic cmd_go = 1'b0, cmd_init = 1'b0;
    logic [RW-1:0] rate_in = '0;
    logic card_clk, clk_running, clk_off, init_busy, cmd_launch;
    logic [RW-1:0] rate_out;

    always #2.5 clk = ~clk;

    cardclk_gen dut (
        .clk(clk), .rst_n(rst_n), .rate_wr(rate_wr), .rate_in(rate_in),
        .start_stb(start_stb), .stop_stb(stop_stb), .off_clr(off_clr),
        .cmd_go(cmd_go), .cmd_init(cmd_init), .card_clk(card_clk),
        .clk_running(clk_running), .clk_off(clk_off), .rate_out(rate_out),
        .init_busy(init_busy), .cmd_launch(cmd_launch)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0, n_launch = 0;
    bit finished = 0;

    // behavioural reference state
    int m_rate = MAXE, m_phase = 0, m_icnt = 0;
    bit m_run = 0, m_pend = 0, m_off = 0, m_busy = 0, m_launch = 0, m_fallq = 0;

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        bit fall_now, halt;
        int half;
        cyc++;
        if (!rst_n) begin
            m_rate = MAXE; m_phase = 0; m_icnt = 0; m_run = 0; m_pend = 0;
            m_off = 0; m_busy = 0; m_launch = 0; m_fallq = 0;
        end else begin
            fall_now = 0; halt = 0;
            half = 1 << m_rate;
            if (rate_wr && int'(rate_in) <= MAXE && !m_run) m_rate = int'(rate_in);
            if (!m_run) begin
                if (start_stb && !stop_stb) begin m_run = 1; m_phase = 0; end
            end else begin
                if (stop_stb) m_pend = 1;
                m_phase++;
                if (m_phase == 2 * half) begin
                    m_phase = 0; fall_now = 1;
                    if (m_pend) begin m_run = 0; m_pend = 0; halt = 1; end
                end
            end
            if (halt) m_off = 1; else if (off_clr) m_off = 0;
            m_launch = 0;
            if (!m_busy) begin
                if (cmd_go) begin
                    if (cmd_init) begin m_busy = 1; m_icnt = 0; end
                    else m_launch = 1;
                end
            end else if (m_fallq) begin
                if (m_icnt == INITN - 1) begin m_busy = 0; m_launch = 1; end
                else m_icnt++;
            end
            m_fallq = fall_now;
        end
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check("R1 R4 R5 card_clk", int'(card_clk),
                  (m_run && m_phase >= (1 << m_rate)) ? 1 : 0);
            check("R6 clk_running", int'(clk_running), int'(m_run));
            check("R7 clk_off", int'(clk_off), int'(m_off));
            check("R1 R2 R3 rate_out", int'(rate_out), m_rate);
            check("R9 R10 init_busy", int'(init_busy), int'(m_busy));
            check("R8 R9 cmd_launch", int'(cmd_launch), int'(m_launch));
            if (cmd_launch) n_launch++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_rate(input int v);
        rate_in = RW'(v); rate_wr = 1'b1; tick(1); rate_wr = 1'b0;
    endtask

    task automatic do_start();
        start_stb = 1'b1; tick(1); start_stb = 1'b0;
    endtask

    task automatic do_stop();
        stop_stb = 1'b1; tick(1); stop_stb = 1'b0;
    endtask

    task automatic wait_halt();
        while (clk_running) tick(1);
    endtask

    int lc;

    initial begin
        tick(3);
        check("R11 reset card_clk", int'(card_clk), 0);
        check("R11 reset running", int'(clk_running), 0);
        check("R11 reset off", int'(clk_off), 0);
        check("R11 reset rate", int'(rate_out), MAXE);
        check("R11 reset busy/launch", int'(init_busy | cmd_launch), 0);
        rst_n = 1'b1;
        tick(2);

        wr_rate(7);
        check("R2 illegal exponent ignored", int'(rate_out), MAXE);
        wr_rate(2);
        check("R1 exponent accepted", int'(rate_out), 2);

        do_start();
        check("R6 running after start", int'(clk_running), 1);
        check("R4 first half low", int'(card_clk), 0);
        tick(2);
        check("R4 still low inside first half", int'(card_clk), 0);
        wr_rate(5);
        check("R3 write while running ignored", int'(rate_out), 2);
        tick(3);
        do_start();
        tick(7);
        do_stop();
        check("R5 no early halt", int'(clk_running), 1);
        wait_halt();
        check("R5 parked low", int'(card_clk), 0);
        check("R7 off flag set", int'(clk_off), 1);
        tick(4);
        check("R7 flag sticky", int'(clk_off), 1);
        off_clr = 1'b1; tick(1); off_clr = 1'b0;
        check("R7 flag cleared", int'(clk_off), 0);

        start_stb = 1'b1; stop_stb = 1'b1; tick(1); start_stb = 1'b0; stop_stb = 1'b0;
        check("R4 start with stop stays stopped", int'(clk_running), 0);

        wr_rate(0);
        do_start();
        lc = n_launch;
        cmd_go = 1'b1; cmd_init = 1'b0; tick(1); cmd_go = 1'b0;
        check("R8 launch one cycle after go", int'(cmd_launch), 1);
        tick(1);
        check("R8 single launch", n_launch - lc, 1);

        lc = n_launch;
        cmd_go = 1'b1; cmd_init = 1'b1; tick(1); cmd_go = 1'b0; cmd_init = 1'b0;
        check("R9 burst busy", int'(init_busy), 1);
        tick(10);
        cmd_go = 1'b1; tick(1); cmd_go = 1'b0;
        check("R10 go during burst ignored", n_launch - lc, 0);
        while (init_busy) tick(1);
        check("R9 launch at burst end", int'(cmd_launch), 1);
        tick(3);
        check("R9 exactly one launch", n_launch - lc, 1);

        stop_stb = 1'b1; off_clr = 1'b1;
        while (clk_running) tick(1);
        stop_stb = 1'b0; off_clr = 1'b0;
        check("R7 set wins over clear", int'(clk_off), 1);
        off_clr = 1'b1; tick(1); off_clr = 1'b0;

        wr_rate(1);
        do_start();
        cmd_go = 1'b1; cmd_init = 1'b1; tick(1); cmd_go = 1'b0; cmd_init = 1'b0;
        tick(60);
        do_stop();
        wait_halt();
        tick(20);
        check("R9 burst paused while stopped", int'(init_busy), 1);
        do_start();
        while (init_busy) tick(1);
        tick(2);

        wr_rate(6);
        do_start();
        tick(70);
        do_stop();
        wait_halt();
        do_start();
        tick(5);
        do_stop();
        wait_halt();
        tick(4);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule